// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and turns each one into an active-high level request for a parent interrupt controller. Every pin is first brought into the clock domain by a two-flop synchroniser. A 2-bit sense code per line then selects how it is interpreted: as an active-low level, or as a falling, rising or any edge.

In the edge modes a detected event sets a sticky status bit. Software clears that bit by writing 0 to it. In the low-level mode the status bit simply mirrors the inverted pin, and software writes to it are ignored. A per-line mask bit suppresses the request output. A masked line still records its status, so unmasking it later raises the request at once.

Software reaches the status, sense and mask registers over a plain 32-bit register bus. The bus carries an address, a write strobe and write data, and returns read data combinationally.

Top module: `extint_sense_ctrl`

## Requirements
- R1: The sense register at offset 0x14 holds a 2-bit code for line n in bits [2n+1:2n] and reads back what was written.
- R2: With sense code 1, a high-to-low transition of the synchronised pin sets status bit n; a low-to-high transition does not set it.
- R3: With sense code 2, a low-to-high transition sets status bit n; a high-to-low transition does not set it.
- R4: With sense code 3, either transition direction sets status bit n.
- R5: With sense code 0, status bit n equals the inverse of the synchronised pin, and writing 0 to it has no effect.
- R6: The status register at offset 0x10 holds line n at bit n. In any edge mode (codes 1 to 3), writing 0 to bit n clears it and writing 1 leaves it unchanged.
- R7: If an edge is detected in the same cycle as a clear write to that line, the status bit stays set.
- R8: The mask register at offset 0x10010 holds line n at bit n, with 1 meaning masked. A masked line drives its request low but still sets its status bit.
- R9: Request output n is high exactly when status bit n is 1 and mask bit n is 0.
- R10: After reset, the sense, status and mask registers all read 0, and no request is raised while the pins are high.
- R11: Register bits above the implemented fields read as 0 and ignore writes. Any other address reads 0 and ignores writes.
- R12: A pin transition applied between clock edges appears in the status register after the third following rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_irq_i | input | 8 | Asynchronous external interrupt pins, line n on bit n |
| bus_addr_i | input | 17 | Register byte address |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_req_o | output | 8 | Active-high level requests to the parent controller |

## Verification
The embedded assertions check the following on every cycle:
- a low-level line tracks its inverted synchronised pin;
- a clear with no edge drops the status bit;
- an edge beats a simultaneous clear;
- an edge-mode status bit holds when nothing acts on it;
- mask and sense writes land;
- unused read bits stay zero.

Only the directed scenarios can show the end-to-end behaviour. This covers which transition direction each sense code accepts, the exact three-edge latency from pin to status, the masking and unmasking of a pending request, and the behaviour of unmapped addresses.

// File: rtl/extint_pkg.sv
// Package: shared types and register offsets of the external interrupt
// sense controller. Assumes byte addressing on a 32-bit register bus.
package extint_pkg;

    // Per-line detection mode; the numeric codes are software visible.
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_BOTH = 2'd3
    } sense_e;

    localparam logic [31:0] OFS_STATUS = 32'h0000_0010;
    localparam logic [31:0] OFS_SENSE  = 32'h0000_0014;
    localparam logic [31:0] OFS_MASK   = 32'h0001_0010;

endpackage

// File: rtl/extint_sync.sv
// Module: two-stage synchroniser for a vector of asynchronous pins.
// Assumes the pins idle high; both stages reset to 1 so that a line in
// low-level mode shows no status directly after reset.
module extint_sync #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_i,
    output logic [LINES-1:0] sync_o
);

    logic [LINES-1:0] meta_q;
    logic [LINES-1:0] stable_q;

    // Purpose: shift the pins through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '1;
            stable_q <= '1;
        end else begin
            meta_q   <= pin_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;

endmodule

// File: rtl/extint_line.sv
// Module: event detection and sticky status for one interrupt line.
// Assumes sync_i is already synchronised to clk. In edge modes a detected
// edge has priority over a software clear; in low-level mode the status
// follows the inverted pin and clears are ignored.
module extint_line
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e sense_i,
    input  logic   sync_i,
    input  logic   clr_i,
    output logic   st_o
);

    logic prev_q;
    logic st_q;
    logic rise;
    logic fall;
    logic hit;

    // Purpose: find transitions and pick those the sense code accepts.
    always_comb begin
        rise = sync_i & ~prev_q;
        fall = ~sync_i & prev_q;
        unique case (sense_i)
            SENSE_FALL: hit = fall;
            SENSE_RISE: hit = rise;
            SENSE_BOTH: hit = rise | fall;
            default:    hit = 1'b0;
        endcase
    end

    // Purpose: remember the last pin value and update the status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            st_q   <= 1'b0;
        end else begin
            prev_q <= sync_i;
            if (sense_i == SENSE_LOW) begin
                st_q <= ~sync_i;
            end else if (hit) begin
                st_q <= 1'b1;
            end else if (clr_i) begin
                st_q <= 1'b0;
            end
        end
    end

    assign st_o = st_q;

    // R5: level mode status mirrors the inverted pin one cycle later
    a_r5_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i == SENSE_LOW) |=> (st_o == !$past(sync_i)));

    // R7: an edge in the same cycle as a clear keeps the bit set
    a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i != SENSE_LOW && hit && clr_i) |=> st_o);

    // R6: a clear with no competing edge drops the bit
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i != SENSE_LOW && clr_i && !hit) |=> !st_o);

    // R6: edge-mode status holds when nothing acts on it
    a_r6_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i != SENSE_LOW && !clr_i && !hit) |=> $stable(st_o));

endmodule

// File: rtl/extint_regs.sv
// Module: register bank holding sense codes and mask bits, producing
// per-line clear strobes from status writes, and the read multiplexer.
// Assumes full address decode; unmapped addresses read zero.
module extint_regs
    import extint_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int ADDR_W = 17,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_we_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    input  logic [LINES-1:0]     status_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic [2*LINES-1:0]   sense_o,
    output logic [LINES-1:0]     mask_o,
    output logic [LINES-1:0]     clr_o
);

    localparam int SENSE_W = 2 * LINES;

    logic [SENSE_W-1:0] sense_q;
    logic [LINES-1:0]   mask_q;
    logic               sel_status;
    logic               sel_sense;
    logic               sel_mask;
    logic               unused_wdata;

    assign sel_status   = (bus_addr_i == ADDR_W'(OFS_STATUS));
    assign sel_sense    = (bus_addr_i == ADDR_W'(OFS_SENSE));
    assign sel_mask     = (bus_addr_i == ADDR_W'(OFS_MASK));
    assign unused_wdata = ^bus_wdata_i[DATA_W-1:SENSE_W];

    // Purpose: store sense codes and mask bits on bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            mask_q  <= '0;
        end else if (bus_we_i) begin
            if (sel_sense) sense_q <= bus_wdata_i[SENSE_W-1:0];
            if (sel_mask)  mask_q  <= bus_wdata_i[LINES-1:0];
        end
    end

    // Purpose: a status write clears every line whose data bit is zero.
    always_comb begin
        clr_o = '0;
        if (bus_we_i && sel_status) clr_o = ~bus_wdata_i[LINES-1:0];
    end

    // Purpose: return the addressed register, zero extended.
    always_comb begin
        bus_rdata_o = '0;
        if (sel_status)     bus_rdata_o[LINES-1:0]   = status_i;
        else if (sel_sense) bus_rdata_o[SENSE_W-1:0] = sense_q;
        else if (sel_mask)  bus_rdata_o[LINES-1:0]   = mask_q;
    end

    assign sense_o = sense_q;
    assign mask_o  = mask_q;

    // R1: a sense write is visible on the next cycle
    a_r1_sense_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && sel_sense) |=> (sense_o == $past(bus_wdata_i[SENSE_W-1:0])));

    // R8: a mask write is visible on the next cycle
    a_r8_mask_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && sel_mask) |=> (mask_o == $past(bus_wdata_i[LINES-1:0])));

    // R11: bits above the line fields of status reads are zero
    a_r11_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sel_status |-> (bus_rdata_o[DATA_W-1:LINES] == '0));

endmodule

// File: rtl/extint_sense_ctrl.sv
// Module: top of the external interrupt sense controller. Synchronises
// the pins, runs one detector per line and gates status with the mask
// to form level-high requests. Assumes a single clock domain for the bus.
module extint_sense_ctrl
    import extint_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int ADDR_W = 17,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  ext_irq_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [LINES-1:0]  irq_req_o
);

    logic [LINES-1:0]   sync;
    logic [LINES-1:0]   status;
    logic [LINES-1:0]   mask;
    logic [LINES-1:0]   clr;
    logic [2*LINES-1:0] sense;

    extint_sync #(.LINES(LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_irq_i),
        .sync_o (sync)
    );

    extint_regs #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr_i),
        .bus_we_i    (bus_we_i),
        .bus_wdata_i (bus_wdata_i),
        .status_i    (status),
        .bus_rdata_o (bus_rdata_o),
        .sense_o     (sense),
        .mask_o      (mask),
        .clr_o       (clr)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        extint_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .sense_i (sense_e'(sense[2*n +: 2])),
            .sync_i  (sync[n]),
            .clr_i   (clr[n]),
            .st_o    (status[n])
        );
    end

    // Purpose: a request is raised for every pending, unmasked line.
    assign irq_req_o = status & ~mask;

endmodule

// File: tb/extint_sense_ctrl_test.sv
`timescale 1ns/1ps
module extint_sense_ctrl_test;

    localparam logic [16:0] A_STATUS = 17'h00010;
    localparam logic [16:0] A_SENSE  = 17'h00014;
    localparam logic [16:0] A_MASK   = 17'h10010;
    localparam logic [16:0] A_HOLE   = 17'h00020;
    // line0 low, 1 fall, 2 rise, 3 both, 4 fall, 5 both, 6 rise, 7 low
    localparam logic [31:0] CFG      = 32'h0000_2DE4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = 8'hFF;
    logic [16:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    extint_sense_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_irq_i   (pins),
        .bus_addr_i  (bus_addr),
        .bus_we_i    (bus_we),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_req_o   (irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [16:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [16:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic t_reset;
        rd_check("R10 status", A_STATUS, 32'h0);
        rd_check("R10 sense", A_SENSE, 32'h0);
        rd_check("R10 mask", A_MASK, 32'h0);
        check("R10 irq", {24'h0, irq}, 32'h0);
    endtask

    task automatic t_sense_rw;
        wr(A_SENSE, 32'hFFFF_FFFF);
        rd_check("R1 R11 sense upper bits", A_SENSE, 32'h0000_FFFF);
        wr(A_SENSE, CFG);
        rd_check("R1 sense readback", A_SENSE, CFG);
    endtask

    task automatic t_level;
        pins[0] = 1'b0; cyc(4);
        rd_check("R5 level low sets", A_STATUS, 32'h01);
        check("R9 level irq", {24'h0, irq}, 32'h01);
        wr(A_STATUS, 32'h0);
        rd_check("R5 clear ignored", A_STATUS, 32'h01);
        pins[0] = 1'b1; cyc(4);
        rd_check("R5 level release", A_STATUS, 32'h0);
    endtask

    task automatic t_falling;
        pins[1] = 1'b0; cyc(4);
        rd_check("R2 falling sets", A_STATUS, 32'h02);
        pins[1] = 1'b1; cyc(4);
        rd_check("R2 latched after release", A_STATUS, 32'h02);
        wr(A_STATUS, 32'h0);
        rd_check("R6 clear by zero", A_STATUS, 32'h0);
        pins[1] = 1'b0; cyc(4);
        wr(A_STATUS, 32'h0);
        pins[1] = 1'b1; cyc(4);
        rd_check("R2 rising ignored", A_STATUS, 32'h0);
    endtask

    task automatic t_rising;
        pins[2] = 1'b0; cyc(4);
        rd_check("R3 falling ignored", A_STATUS, 32'h0);
        pins[2] = 1'b1; cyc(4);
        rd_check("R3 rising sets", A_STATUS, 32'h04);
        wr(A_STATUS, 32'hFF);
        rd_check("R6 write one no effect", A_STATUS, 32'h04);
        wr(A_STATUS, 32'h0);
        rd_check("R6 rising cleared", A_STATUS, 32'h0);
    endtask

    task automatic t_both;
        pins[3] = 1'b0; cyc(4);
        rd_check("R4 fall sets", A_STATUS, 32'h08);
        wr(A_STATUS, 32'h0);
        pins[3] = 1'b1; cyc(4);
        rd_check("R4 rise sets", A_STATUS, 32'h08);
        wr(A_STATUS, 32'h0);
        rd_check("R4 cleared", A_STATUS, 32'h0);
    endtask

    task automatic t_latency;
        pins[4] = 1'b0; cyc(2);
        rd_check("R12 not after two edges", A_STATUS, 32'h0);
        cyc(1);
        rd_check("R12 set after three edges", A_STATUS, 32'h10);
        wr(A_STATUS, 32'h0);
        pins[4] = 1'b1; cyc(4);
        rd_check("R12 line idle", A_STATUS, 32'h0);
    endtask

    task automatic t_race;
        pins[5] = 1'b0; cyc(4);
        rd_check("R7 first edge", A_STATUS, 32'h20);
        pins[5] = 1'b1; cyc(2);
        wr(A_STATUS, 32'h0);
        rd_check("R7 edge beats clear", A_STATUS, 32'h20);
        wr(A_STATUS, 32'h0);
        rd_check("R7 later clear", A_STATUS, 32'h0);
    endtask

    task automatic t_mask;
        wr(A_MASK, 32'h40);
        rd_check("R8 mask readback", A_MASK, 32'h40);
        pins[6] = 1'b0; cyc(4);
        pins[6] = 1'b1; cyc(4);
        rd_check("R8 masked still latches", A_STATUS, 32'h40);
        check("R8 masked no request", {24'h0, irq}, 32'h0);
        wr(A_MASK, 32'h0);
        check("R9 unmask raises request", {24'h0, irq}, 32'h40);
        wr(A_MASK, 32'hFFFF_FFFF);
        rd_check("R11 mask upper bits", A_MASK, 32'hFF);
        check("R8 all masked", {24'h0, irq}, 32'h0);
        wr(A_MASK, 32'h0);
        wr(A_STATUS, 32'h0);
        check("R9 no request after clear", {24'h0, irq}, 32'h0);
    endtask

    task automatic t_hole;
        rd_check("R11 unmapped reads zero", A_HOLE, 32'h0);
        wr(A_HOLE, 32'hFFFF_FFFF);
        rd_check("R11 unmapped write ignored", A_SENSE, CFG);
        rd_check("R11 mask untouched", A_MASK, 32'h0);
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_sense_rw();
        t_level();
        t_falling();
        t_rising();
        t_both();
        t_latency();
        t_race();
        t_mask();
        t_hole();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule